// File: doc/BRIEF.md
# Serial Register Control Port

This block is a four-wire serial slave that lets an external host read and write a small internal register file. The serial pins are sampled by the block's own system clock through synchronisers, so every internal event is an ordinary clocked pulse. A frame opens when chip select falls. It then carries a 16-bit instruction and one or more data bytes. The instruction holds a direction flag, a byte-count code and a 13-bit start address. Between data bytes the address steps on by itself, and the direction of the step depends on the bit order in use.

Host writes to the register bank land in a shadow copy. The active copy, which the rest of the chip sees on `act_bank` and which reads return, changes only when the host sets a self-clearing commit bit. The copy then happens on the next serial clock rising edge. A configuration byte at address 0 sets the bit order and the read-data pin. The block accepts a write to that byte only when its upper nibble is the bit-reverse of its lower nibble. This makes the byte read the same in either bit order.

Top module: `spi_regctl`

## Requirements
- R1: A frame starts when `csb` falls. Its first 16 bits form the instruction: bit 15 is the direction (1 = read), bits 14:13 are the byte-count code and bits 12:0 the start address. A write to bank address 1..DEPTH-1 changes only the shadow copy and leaves `act_bank` unchanged.
- R2: Count codes 00, 01 and 10 carry exactly 1, 2 and 3 data bytes. Once that many bytes are done, further serial clocks before `csb` rises write nothing.
- R3: Count code 11 streams. Bytes keep transferring until `csb` rises on a byte boundary.
- R4: In a counted frame, `csb` going high on a byte boundary pauses the frame. When `csb` falls again, the transfer resumes at the next address.
- R5: In MSB-first mode each later data byte goes to the address one below the previous one. In LSB-first mode it goes to the address one above.
- R6: Configuration byte at address 0: bit 1 (mirrored in bit 6) selects LSB-first and bit 0 (mirrored in bit 7) selects unidirectional mode. A write is accepted only when bits 7:4 equal bits 0,1,2,3 of the byte. A rejected write leaves the old value. A new bit order applies from the next frame, to the instruction and to the data alike.
- R7: Writing a byte with bit 0 set to address 0x232 copies the whole shadow bank into the active bank on the next `sclk` rising edge, whether or not a frame is in progress. Reads of bank addresses return the active copy.
- R8: In bidirectional mode, read data leaves on `sdio_o` with `sdio_oe` high and `sdo_oe` low. In unidirectional mode it leaves on `sdo` with `sdo_oe` high and `sdio_oe` low. Both enables are low outside the data phase of a read.
- R9: If `csb` rises part-way through the instruction or a data byte, the frame is abandoned, the partial byte writes nothing, and the next frame works normally.
- R10: After reset the configuration byte reads 0 (MSB first, bidirectional), `act_bank` is all zero and both output enables are low.
- R11: Writes to addresses outside the configuration byte, the commit register and the bank are ignored. Reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in on the shared pin |
| sdio_o | output | 1 | Read data on the shared pin (bidirectional mode) |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| sdo | output | 1 | Read data on the separate output pin (unidirectional mode) |
| sdo_oe | output | 1 | Drive enable for the separate output pin |
| act_bank | output | 8*DEPTH | Active register bank, byte i at bits 8i+7:8i |

## Verification
Single-byte writes and reads at fixed addresses show that the instruction is decoded and that the shadow and active copies stay separate. Multi-byte frames with codes 01, 10 and 11, including one with a surplus byte, check the byte counting and the address stepping: a wrong count or a wrong step direction lands bytes on neighbouring registers, and those registers hold known values. Frames broken by chip select, either at a byte boundary or mid-byte, tell a pause apart from an abandoned frame. Repeating writes and reads after LSB-first and unidirectional modes are switched on shows that the bit order is reversed over the whole frame and that read data moves to the other pin.

// File: rtl/spi_rc_pkg.sv
package spi_rc_pkg;
  localparam int AW = 13;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_DONE} fr_state_t;

  // upper nibble must be the bit-reverse of the lower nibble
  function automatic logic mirror_ok(input logic [7:0] b);
    return b[7:4] == {b[0], b[1], b[2], b[3]};
  endfunction

  // address after a data byte: up in LSB-first, down in MSB-first
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic lsb);
    return lsb ? a + 1'b1 : a - 1'b1;
  endfunction

  // bit sent at position idx of a byte for the given order
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] idx, input logic lsb);
    return lsb ? b[idx] : b[3'd7 - idx];
  endfunction
endpackage

// File: rtl/spi_rc_sync.sv
module spi_rc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic csb,
  input  logic sdi,
  output logic sclk_rise,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sdi_s
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sck_p, cs_p, sd_p;
  logic sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      sd_p  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_p <= {sck_p[STAGES-2:0], sclk};
      cs_p  <= {cs_p[STAGES-2:0], csb};
      sd_p  <= {sd_p[STAGES-2:0], sdi};
      sck_d <= sck_p[TOP];
      cs_d  <= cs_p[TOP];
    end
  end

  assign sclk_rise = sck_p[TOP] & ~sck_d;
  assign cs_low    = ~cs_p[TOP];
  assign cs_fall   = ~cs_p[TOP] & cs_d;
  assign cs_rise   = cs_p[TOP] & ~cs_d;
  assign sdi_s     = sd_p[TOP];
endmodule

// File: rtl/spi_rc_frame.sv
module spi_rc_frame
  import spi_rc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_rise,
  input  logic          cs_low,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          sdi,
  input  logic          cfg_lsb,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] cur_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_active,
  output logic          rd_bit
);
  fr_state_t     state;
  logic [3:0]    bitcnt;
  logic [15:0]   hdr;
  logic [7:0]    dat;
  logic          rw, stream, lsb_q;
  logic [1:0]    left;
  logic [15:0]   nh;
  logic [7:0]    nd;

  assign nh = lsb_q ? {sdi, hdr[15:1]} : {hdr[14:0], sdi};
  assign nd = lsb_q ? {sdi, dat[7:1]}  : {dat[6:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      hdr      <= '0;
      dat      <= '0;
      rw       <= 1'b0;
      stream   <= 1'b0;
      lsb_q    <= 1'b0;
      left     <= '0;
      cur_addr <= '0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_rise) begin
        case (state)
          ST_HDR:  state <= ST_IDLE;
          ST_DATA: if (bitcnt != 4'd0 || stream) state <= ST_IDLE;
          ST_DONE: state <= ST_IDLE;
          default: ;
        endcase
      end else if (cs_fall && state == ST_IDLE) begin
        state  <= ST_HDR;
        bitcnt <= '0;
        lsb_q  <= cfg_lsb;
      end else if (sclk_rise && cs_low) begin
        case (state)
          ST_HDR: begin
            hdr <= nh;
            if (bitcnt == 4'd15) begin
              state    <= ST_DATA;
              bitcnt   <= '0;
              rw       <= nh[15];
              stream   <= (nh[14:13] == 2'b11);
              left     <= nh[14:13];
              cur_addr <= nh[12:0];
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          ST_DATA: begin
            dat <= nd;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              if (!rw) begin
                wr_stb  <= 1'b1;
                wr_addr <= cur_addr;
                wr_data <= nd;
              end
              cur_addr <= step_addr(cur_addr, lsb_q);
              if (!stream) begin
                if (left == 2'd0) state <= ST_DONE;
                else              left  <= left - 2'd1;
              end
            end else begin
              bitcnt <= bitcnt + 4'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_active = (state == ST_DATA) && rw && cs_low;
  assign rd_bit    = pick_bit(rd_byte, bitcnt[2:0], lsb_q);

  // R4: a paused counted frame keeps its place
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !cs_low && !cs_rise) |=> (state == ST_DATA && $stable(cur_addr)));

  // R9: chip select rising mid-byte abandons the frame without a write
  assert_partial_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && state == ST_DATA && bitcnt != 4'd0) |=> (state == ST_IDLE && !wr_stb));

  // R2: no write once the counted bytes are finished
  assert_count_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && $past(state) == ST_DONE) |-> !wr_stb);
endmodule

// File: rtl/spi_rc_regs.sv
module spi_rc_regs
  import spi_rc_pkg::*;
#(
  parameter int           DEPTH    = 8,
  parameter logic [12:0]  UPD_ADDR = 13'h232
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             sclk_rise,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_byte,
  output logic             cfg_lsb,
  output logic             cfg_uni,
  output logic [8*DEPTH-1:0] act_flat
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0] shadow [DEPTH];
  logic [7:0] active [DEPTH];
  logic [7:0] cfg;
  logic       upd_pend;
  logic       commit;
  logic [8*DEPTH-1:0] sh_flat;

  assign commit = upd_pend && sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end
      cfg      <= '0;
      upd_pend <= 1'b0;
    end else begin
      if (commit) begin
        for (int i = 0; i < DEPTH; i++) active[i] <= shadow[i];
        upd_pend <= 1'b0;
      end
      if (wr_stb) begin
        if (wr_addr == '0) begin
          if (mirror_ok(wr_data)) cfg <= wr_data;
        end else if (wr_addr == UPD_ADDR) begin
          if (wr_data[0]) upd_pend <= 1'b1;
        end else if (wr_addr < AW'(DEPTH)) begin
          shadow[wr_addr[IW-1:0]] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    if (rd_addr == '0)                rd_byte = cfg;
    else if (rd_addr == UPD_ADDR)     rd_byte = {7'd0, upd_pend};
    else if (rd_addr < AW'(DEPTH))    rd_byte = active[rd_addr[IW-1:0]];
    else                              rd_byte = 8'd0;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign act_flat[g*8 +: 8] = active[g];
      assign sh_flat[g*8 +: 8]  = shadow[g];
    end
  endgenerate

  assign cfg_lsb = cfg[1];
  assign cfg_uni = cfg[0];

  // R6: the stored configuration byte is always mirrored
  assert_cfg_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_ok(cfg));

  // R7: a commit copies the shadow bank and clears the request
  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_flat == $past(sh_flat) && !upd_pend));

  // R7: without a commit the active bank holds
  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_flat));
endmodule

// File: rtl/spi_regctl.sv
module spi_regctl
  import spi_rc_pkg::*;
#(
  parameter int          DEPTH       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [12:0] UPD_ADDR    = 13'h232
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               csb,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [8*DEPTH-1:0] act_bank
);
  logic          sclk_rise, cs_low, cs_fall, cs_rise, sdi_s;
  logic          cfg_lsb, cfg_uni;
  logic [7:0]    rd_byte;
  logic [AW-1:0] cur_addr, wr_addr;
  logic          wr_stb;
  logic [7:0]    wr_data;
  logic          rd_active, rd_bit;

  spi_rc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdi(sdio_i),
    .sclk_rise(sclk_rise), .cs_low(cs_low), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sdi_s(sdi_s)
  );

  spi_rc_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_low(cs_low),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sdi(sdi_s), .cfg_lsb(cfg_lsb),
    .rd_byte(rd_byte), .cur_addr(cur_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_active(rd_active), .rd_bit(rd_bit)
  );

  spi_rc_regs #(.DEPTH(DEPTH), .UPD_ADDR(UPD_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .sclk_rise(sclk_rise), .rd_addr(cur_addr),
    .rd_byte(rd_byte), .cfg_lsb(cfg_lsb), .cfg_uni(cfg_uni), .act_flat(act_bank)
  );

  assign sdio_oe = rd_active & ~cfg_uni;
  assign sdo_oe  = rd_active & cfg_uni;
  assign sdio_o  = sdio_oe & rd_bit;
  assign sdo     = sdo_oe & rd_bit;
endmodule

// File: tb/spi_regctl_test.sv
module spi_regctl_test;
  localparam int DEPTH = 8;
  localparam logic [12:0] UPD = 13'h232;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csb = 1'b1;
  logic sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo, sdo_oe;
  logic [8*DEPTH-1:0] act_bank;

  int total = 0;
  int bad = 0;
  bit mode_lsb = 0;
  bit mode_uni = 0;
  logic seen_io_oe, seen_o_oe;

  always #5 clk = ~clk;

  spi_regctl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .act_bank(act_bank)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic o);
    sdio_i = b;
    half();
    o = mode_uni ? sdo : sdio_o;
    seen_io_oe = sdio_oe;
    seen_o_oe  = sdo_oe;
    sclk = 1'b1;
    half();
    sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] v, output logic [7:0] r);
    logic b;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = mode_lsb ? i : 7 - i;
      xbit(v[k], b);
      r[k] = b;
    end
  endtask

  task automatic send_hdr(input logic rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    logic [7:0] d;
    w = {rw, len, a};
    if (mode_lsb) begin xbyte(w[7:0], d); xbyte(w[15:8], d); end
    else          begin xbyte(w[15:8], d); xbyte(w[7:0], d); end
  endtask

  task automatic cs_lo(); csb = 1'b0; half(); endtask
  task automatic cs_hi(); half(); csb = 1'b1; half(); half(); endtask

  task automatic frame(input logic rw, input logic [1:0] len, input logic [12:0] a,
                       input int n, input logic [63:0] wd, output logic [63:0] rd);
    logic [7:0] r;
    rd = '0;
    cs_lo();
    send_hdr(rw, len, a);
    for (int i = 0; i < n; i++) begin
      xbyte(wd[8*i +: 8], r);
      rd[8*i +: 8] = r;
    end
    cs_hi();
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    logic [63:0] rd;
    frame(1'b0, 2'b00, a, 1, {56'd0, v}, rd);
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] v);
    logic [63:0] rd;
    frame(1'b1, 2'b00, a, 1, 64'd0, rd);
    v = rd[7:0];
  endtask

  task automatic pulse_sclk();
    half(); sclk = 1'b1; half(); sclk = 1'b0; half();
  endtask

  task automatic commit();
    wr1(UPD, 8'h01);
    pulse_sclk();
  endtask

  function automatic logic [7:0] actb(input int a);
    return act_bank[8*a +: 8];
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    chk(act_bank == '0, "R10 bank", act_bank, 0);
    chk(!sdio_oe && !sdo_oe, "R10 enables", {sdio_oe, sdo_oe}, 0);
    rd1(13'h0, v);
    chk(v == 8'h00, "R10 cfg", v, 0);
    chk(seen_io_oe && !seen_o_oe, "R8 bidir enables", {seen_io_oe, seen_o_oe}, 2'b10);
  endtask

  task automatic t_shadow();
    logic [7:0] v;
    wr1(13'd3, 8'hA5);
    chk(actb(3) == 8'h00, "R1 shadow only", actb(3), 0);
    rd1(13'd3, v);
    chk(v == 8'h00, "R7 read active", v, 0);
    wr1(UPD, 8'h01);
    chk(actb(3) == 8'h00, "R7 waits for sclk", actb(3), 0);
    pulse_sclk();
    chk(actb(3) == 8'hA5, "R7 commit", actb(3), 8'hA5);
  endtask

  task automatic t_counted();
    logic [63:0] rd;
    frame(1'b0, 2'b10, 13'd6, 4, 64'h77332211, rd);
    commit();
    chk(actb(6) == 8'h11 && actb(5) == 8'h22 && actb(4) == 8'h33, "R5 msb decrement",
        {actb(6), actb(5), actb(4)}, 24'h112233);
    chk(actb(3) == 8'hA5, "R2 surplus byte ignored", actb(3), 8'hA5);
  endtask

  task automatic t_read_bidir();
    logic [63:0] rd;
    frame(1'b1, 2'b01, 13'd6, 2, 64'd0, rd);
    chk(rd[15:0] == 16'h2211, "R8 bidir read data", rd[15:0], 16'h2211);
    chk(seen_io_oe && !seen_o_oe, "R8 bidir pin", {seen_io_oe, seen_o_oe}, 2'b10);
    chk(!sdio_oe && !sdo_oe, "R8 enables idle", {sdio_oe, sdo_oe}, 0);
  endtask

  task automatic t_stall();
    logic [7:0] r;
    cs_lo();
    send_hdr(1'b0, 2'b01, 13'd2);
    xbyte(8'h5A, r);
    cs_hi();
    cs_lo();
    xbyte(8'hC3, r);
    cs_hi();
    commit();
    chk(actb(2) == 8'h5A && actb(1) == 8'hC3, "R4 stall resume", {actb(2), actb(1)}, 16'h5AC3);
  endtask

  task automatic t_abort();
    logic b;
    cs_lo();
    send_hdr(1'b0, 2'b00, 13'd7);
    for (int i = 0; i < 5; i++) xbit(1'b1, b);
    cs_hi();
    cs_lo();
    for (int i = 0; i < 9; i++) xbit(1'b0, b);
    cs_hi();
    commit();
    chk(actb(7) == 8'h00, "R9 partial byte dropped", actb(7), 0);
    wr1(13'd7, 8'h3C);
    commit();
    chk(actb(7) == 8'h3C, "R9 recovery", actb(7), 8'h3C);
  endtask

  task automatic t_stream();
    logic [63:0] rd;
    frame(1'b0, 2'b11, 13'd7, 5, 64'hE5E4E3E2E1, rd);
    commit();
    chk(actb(7) == 8'hE1 && actb(6) == 8'hE2 && actb(5) == 8'hE3 &&
        actb(4) == 8'hE4 && actb(3) == 8'hE5, "R3 stream five bytes",
        act_bank[63:24], 40'hE1E2E3E4E5);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    logic [63:0] rd;
    wr1(13'h0, 8'h02);
    rd1(13'h0, v);
    chk(v == 8'h00, "R6 unmirrored rejected", v, 0);
    wr1(13'h0, 8'h42);
    mode_lsb = 1;
    rd1(13'h0, v);
    chk(v == 8'h42, "R6 lsb mode readback", v, 8'h42);
    frame(1'b0, 2'b01, 13'd1, 2, 64'h9B9A, rd);
    commit();
    chk(actb(1) == 8'h9A && actb(2) == 8'h9B, "R5 lsb increment", {actb(1), actb(2)}, 16'h9A9B);
  endtask

  task automatic t_uni();
    logic [7:0] v;
    wr1(13'h0, 8'hC3);
    mode_uni = 1;
    rd1(13'd1, v);
    chk(v == 8'h9A, "R8 uni read data", v, 8'h9A);
    chk(!seen_io_oe && seen_o_oe, "R8 uni pin", {seen_io_oe, seen_o_oe}, 2'b01);
  endtask

  task automatic t_unmapped();
    logic [63:0] snap;
    logic [7:0] v;
    snap = act_bank;
    wr1(13'h100, 8'hFF);
    commit();
    chk(act_bank == snap, "R11 write ignored", act_bank, snap);
    rd1(13'h100, v);
    chk(v == 8'h00, "R11 read zero", v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_shadow();
    t_counted();
    t_read_bidir();
    t_stall();
    t_abort();
    t_stream();
    t_cfg();
    t_uni();
    t_unmapped();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule